// File: doc/BRIEF.md
# Sixteen-Pin I/O Port Register File

This block is the software-facing register file of one general-purpose I/O port. A bus master reaches it through single-word reads and writes with a one-cycle registered response. The master configures each pin's direction, drive style, pull and speed. It writes the output levels directly or changes them with atomic bit operations. It reads back the input levels that a separate pin resolution block has already resolved. The block drives its output levels and configuration vectors to that resolution block. It does not model the pad itself.

Each port instance receives its own reset values for the direction, speed and pull registers through parameters. The speed, alternate-function, lock and analog-switch registers only store what is written. Each pin's direction field has four codes. Only the code 01 makes the pin an output, and every other code behaves as input.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, the direction, speed and pull registers hold their per-instance parameter values. The output-type, output-data, lock, both alternate-function and analog-switch registers hold zero.
- R2: Word offsets 0x00 (direction), 0x08 (speed), 0x0C (pull), 0x20 and 0x24 (alternate function, low and high) store all 32 written bits and read them back. Read data appears on `rd_data` in the cycle after the read is presented and holds until the next read.
- R3: The output-type (0x04), output-data (0x14), lock (0x1C) and analog-switch (0x2C) registers keep only written bits 15:0. Their bits 31:16 read as zero.
- R4: A read of offset 0x10 returns `pin_in` as it was at the clock edge that accepts the read. A write to 0x10 changes no register and no output.
- R5: A write to offset 0x18 clears the output-data bits selected by bits 31:16 of the data and sets those selected by bits 15:0 (bit n and bit n+16 belong to pin n). Unselected bits keep their value.
- R6: In a write to 0x18, when both the set and the clear bit of a pin are 1, the pin's output bit ends at 1.
- R7: A write to offset 0x28 clears the output-data bits selected by data bits 15:0 and ignores bits 31:16.
- R8: Reads of offsets 0x18 and 0x28 always return zero.
- R9: `drive_en[n]` is 1 exactly when direction bits 2n+1:2n equal 01. The codes 00, 10 and 11 give 0.
- R10: An access whose address has nonzero bits 1:0, or whose word offset is above 0x2C, reads as zero and writes nothing. A cycle with `bus_valid` low changes nothing.
- R11: `out_level`, `out_kind`, `dir_cfg`, `pull_cfg` and `speed_cfg` show the register contents, and a write shows on them in the cycle after its accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| pin_in | input | NPINS | Resolved pin levels from the pin block |
| out_level | output | NPINS | Output data levels |
| out_kind | output | NPINS | Drive style per pin, 1 = open-drain |
| drive_en | output | NPINS | Pin is in output mode |
| dir_cfg | output | 2*NPINS | Direction fields |
| pull_cfg | output | 2*NPINS | Pull fields |
| speed_cfg | output | 2*NPINS | Speed fields |

## Verification
The bench builds the block with 16 pins and a 6-bit byte address, so every one of the 64 byte addresses can be swept. That sweep covers all twelve defined words, the four undefined ones and every misaligned address. The three reset parameters are set to distinct asymmetric patterns, so a swapped or missing reset load shows up. With 16 pins, the set/clear write uses both half-words in full. The direction sweep therefore covers all four mode codes on every pin, and the atomic operations meet every mix of set and clear bits.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned BUS_W   = 32;
  localparam int unsigned HALF_W  = 16;
  localparam int unsigned N_WORDS = 12;

  // Word index = byte offset / 4; the atomic words are decoded by offset.
  typedef enum logic [3:0] {
    SEL_DIR    = 4'd0,
    SEL_KIND   = 4'd1,
    SEL_SPEED  = 4'd2,
    SEL_PULL   = 4'd3,
    SEL_IN     = 4'd4,
    SEL_OUT    = 4'd5,
    SEL_SETCLR = 4'd6,
    SEL_LOCK   = 4'd7,
    SEL_ALT_LO = 4'd8,
    SEL_ALT_HI = 4'd9,
    SEL_CLR    = 4'd10,
    SEL_ASW    = 4'd11
  } reg_sel_e;

  typedef struct packed {
    logic     wr;
    logic     rd;
    reg_sel_e sel;
  } acc_t;

  localparam logic [1:0] DIR_OUTPUT = 2'b01;

endpackage

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              valid,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output acc_t              acc
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              hit;

  always_comb begin
    word    = addr[ADDR_W-1:2];
    hit     = valid && (addr[1:0] == 2'b00) && (word < WORD_W'(N_WORDS));
    acc.wr  = hit && we;
    acc.rd  = hit && !we;
    acc.sel = reg_sel_e'(word[3:0]);
  end

endmodule

// File: rtl/gpio_port_cfg_reg.sv
module gpio_port_cfg_reg #(
  parameter int unsigned W   = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_n;

  always_comb begin
    q_n = q;
    if (wr_en) q_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else        q <= q_n;
  end

endmodule

// File: rtl/gpio_port_out_data.sv
module gpio_port_out_data
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_full,
  input  logic             wr_setclr,
  input  logic             wr_clr,
  input  logic [BUS_W-1:0] wdata,
  output logic [NPINS-1:0] q
);
  logic [NPINS-1:0] q_n;
  logic [NPINS-1:0] set_bits;
  logic [NPINS-1:0] clr_bits;

  always_comb begin
    set_bits = wdata[NPINS-1:0];
    clr_bits = wdata[HALF_W +: NPINS];
    q_n      = q;
    if (wr_full)        q_n = set_bits;
    else if (wr_setclr) q_n = (q & ~clr_bits) | set_bits;
    else if (wr_clr)    q_n = q & ~set_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_setclr |=> ((q & $past(wdata[NPINS-1:0] & wdata[HALF_W +: NPINS]))
                   == $past(wdata[NPINS-1:0] & wdata[HALF_W +: NPINS])));

  assert_setclr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_setclr |=> ((q & $past(wdata[HALF_W +: NPINS] & ~wdata[NPINS-1:0])) == '0));

  assert_clr_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((q & $past(wdata[NPINS-1:0])) == '0));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS     = 16,
  parameter int unsigned ADDR_W    = 6,
  parameter logic [31:0] DIR_RST   = 32'hFFFF_FFFF,
  parameter logic [31:0] SPEED_RST = 32'h0000_0000,
  parameter logic [31:0] PULL_RST  = 32'h0000_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          rd_data,
  input  logic [NPINS-1:0]     pin_in,
  output logic [NPINS-1:0]     out_level,
  output logic [NPINS-1:0]     out_kind,
  output logic [NPINS-1:0]     drive_en,
  output logic [2*NPINS-1:0]   dir_cfg,
  output logic [2*NPINS-1:0]   pull_cfg,
  output logic [2*NPINS-1:0]   speed_cfg
);
  localparam int unsigned FIELD_W = 2 * NPINS;

  acc_t acc;

  logic [FIELD_W-1:0] dir_q, speed_q, pull_q;
  logic [NPINS-1:0]   kind_q, lock_q, asw_q, out_q;
  logic [BUS_W-1:0]   alt_lo_q, alt_hi_q;
  logic [BUS_W-1:0]   rd_q, rd_n, rd_mux;

  gpio_port_decode #(.ADDR_W(ADDR_W)) decode_i (
    .valid (bus_valid),
    .we    (bus_we),
    .addr  (bus_addr),
    .acc   (acc)
  );

  gpio_port_cfg_reg #(.W(FIELD_W), .RST(DIR_RST[FIELD_W-1:0])) dir_i (
    .clk(clk), .rst_n(rst_n), .wr_en(acc.wr && acc.sel == SEL_DIR),
    .wdata(bus_wdata[FIELD_W-1:0]), .q(dir_q));

  gpio_port_cfg_reg #(.W(FIELD_W), .RST(SPEED_RST[FIELD_W-1:0])) speed_i (
    .clk(clk), .rst_n(rst_n), .wr_en(acc.wr && acc.sel == SEL_SPEED),
    .wdata(bus_wdata[FIELD_W-1:0]), .q(speed_q));

  gpio_port_cfg_reg #(.W(FIELD_W), .RST(PULL_RST[FIELD_W-1:0])) pull_i (
    .clk(clk), .rst_n(rst_n), .wr_en(acc.wr && acc.sel == SEL_PULL),
    .wdata(bus_wdata[FIELD_W-1:0]), .q(pull_q));

  gpio_port_cfg_reg #(.W(NPINS), .RST('0)) kind_i (
    .clk(clk), .rst_n(rst_n), .wr_en(acc.wr && acc.sel == SEL_KIND),
    .wdata(bus_wdata[NPINS-1:0]), .q(kind_q));

  gpio_port_cfg_reg #(.W(NPINS), .RST('0)) lock_i (
    .clk(clk), .rst_n(rst_n), .wr_en(acc.wr && acc.sel == SEL_LOCK),
    .wdata(bus_wdata[NPINS-1:0]), .q(lock_q));

  gpio_port_cfg_reg #(.W(NPINS), .RST('0)) asw_i (
    .clk(clk), .rst_n(rst_n), .wr_en(acc.wr && acc.sel == SEL_ASW),
    .wdata(bus_wdata[NPINS-1:0]), .q(asw_q));

  gpio_port_cfg_reg #(.W(BUS_W), .RST('0)) alt_lo_i (
    .clk(clk), .rst_n(rst_n), .wr_en(acc.wr && acc.sel == SEL_ALT_LO),
    .wdata(bus_wdata), .q(alt_lo_q));

  gpio_port_cfg_reg #(.W(BUS_W), .RST('0)) alt_hi_i (
    .clk(clk), .rst_n(rst_n), .wr_en(acc.wr && acc.sel == SEL_ALT_HI),
    .wdata(bus_wdata), .q(alt_hi_q));

  gpio_port_out_data #(.NPINS(NPINS)) out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_full   (acc.wr && acc.sel == SEL_OUT),
    .wr_setclr (acc.wr && acc.sel == SEL_SETCLR),
    .wr_clr    (acc.wr && acc.sel == SEL_CLR),
    .wdata     (bus_wdata),
    .q         (out_q)
  );

  // Read path: zero-extend narrow registers, atomic words read as zero.
  always_comb begin
    rd_mux = '0;
    unique case (acc.sel)
      SEL_DIR:    rd_mux[FIELD_W-1:0] = dir_q;
      SEL_KIND:   rd_mux[NPINS-1:0]   = kind_q;
      SEL_SPEED:  rd_mux[FIELD_W-1:0] = speed_q;
      SEL_PULL:   rd_mux[FIELD_W-1:0] = pull_q;
      SEL_IN:     rd_mux[NPINS-1:0]   = pin_in;
      SEL_OUT:    rd_mux[NPINS-1:0]   = out_q;
      SEL_LOCK:   rd_mux[NPINS-1:0]   = lock_q;
      SEL_ALT_LO: rd_mux              = alt_lo_q;
      SEL_ALT_HI: rd_mux              = alt_hi_q;
      SEL_ASW:    rd_mux[NPINS-1:0]   = asw_q;
      default:    rd_mux              = '0;
    endcase
  end

  always_comb begin
    rd_n = rd_q;
    if (bus_valid && !bus_we) rd_n = acc.rd ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_n;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign drive_en[p] = (dir_q[2*p +: 2] == DIR_OUTPUT);
  end

  assign rd_data   = rd_q;
  assign out_level = out_q;
  assign out_kind  = kind_q;
  assign dir_cfg   = dir_q;
  assign pull_cfg  = pull_q;
  assign speed_cfg = speed_q;

  assert_atomic_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.rd && (acc.sel == SEL_SETCLR || acc.sel == SEL_CLR)) |=> (rd_data == '0));

  assert_half_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.rd && (acc.sel == SEL_KIND || acc.sel == SEL_OUT ||
                acc.sel == SEL_LOCK || acc.sel == SEL_ASW)) |=> (rd_data[31:16] == '0));

  assert_in_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.wr && acc.sel == SEL_IN) |=>
      ($stable(out_level) && $stable(dir_cfg) && $stable(out_kind) && $stable(pull_cfg)));

  assert_bad_access_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we && !acc.wr) |=>
      ($stable(out_level) && $stable(dir_cfg) && $stable(out_kind) &&
       $stable(pull_cfg) && $stable(speed_cfg)));

  assert_bad_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we && !acc.rd) |=> (rd_data == '0));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> $stable(rd_data));

endmodule

// File: tb/gpio_port_regs_tb.sv
`timescale 1ns/1ps
module gpio_port_regs_tb_top;

  localparam int unsigned NP = 16;
  localparam int unsigned AW = 6;
  localparam logic [31:0] P_DIR   = 32'hA5FF_FF3C;
  localparam logic [31:0] P_SPEED = 32'h0300_0000;
  localparam logic [31:0] P_PULL  = 32'h1400_0040;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_valid, bus_we;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, rd_data;
  logic [NP-1:0] pin_in, out_level, out_kind, drive_en;
  logic [2*NP-1:0] dir_cfg, pull_cfg, speed_cfg;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // model state
  logic [31:0] m_dir, m_speed, m_pull, m_alo, m_ahi;
  logic [15:0] m_kind, m_out, m_lock, m_asw;
  logic [31:0] lfsr;

  always #2.5 clk = ~clk;

  gpio_port_regs #(
    .NPINS(NP), .ADDR_W(AW), .DIR_RST(P_DIR), .SPEED_RST(P_SPEED), .PULL_RST(P_PULL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .pin_in(pin_in), .out_level(out_level), .out_kind(out_kind),
    .drive_en(drive_en), .dir_cfg(dir_cfg), .pull_cfg(pull_cfg),
    .speed_cfg(speed_cfg)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] v);
    logic [31:0] x;
    x = v;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic model_write(input int w, input logic [31:0] d);
    case (w)
      0:  m_dir   = d;
      1:  m_kind  = d[15:0];
      2:  m_speed = d;
      3:  m_pull  = d;
      5:  m_out   = d[15:0];
      6:  m_out   = (m_out & ~d[31:16]) | d[15:0];
      7:  m_lock  = d[15:0];
      8:  m_alo   = d;
      9:  m_ahi   = d;
      10: m_out   = m_out & ~d[15:0];
      11: m_asw   = d[15:0];
      default: ;
    endcase
  endtask

  function automatic logic [31:0] model_read(input int w);
    case (w)
      0:  return m_dir;
      1:  return {16'h0, m_kind};
      2:  return m_speed;
      3:  return m_pull;
      4:  return {16'h0, pin_in};
      5:  return {16'h0, m_out};
      7:  return {16'h0, m_lock};
      8:  return m_alo;
      9:  return m_ahi;
      11: return {16'h0, m_asw};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input int w);
    case (w)
      0, 2, 3, 8, 9:  return "R2";
      1, 5, 7, 11:    return "R3";
      4:              return "R4";
      6, 10:          return "R8";
      default:        return "R10";
    endcase
  endfunction

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = rd_data;
  endtask

  task automatic check_outputs(input string req);
    check(req, {16'h0, out_level}, {16'h0, m_out});
    check(req, dir_cfg, m_dir);
    check(req, {16'h0, out_kind}, {16'h0, m_kind});
    check(req, pull_cfg, m_pull);
    check(req, speed_cfg, m_speed);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; bus_valid = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_in = 16'h5A3C;
    m_dir = P_DIR; m_speed = P_SPEED; m_pull = P_PULL; m_alo = '0; m_ahi = '0;
    m_kind = '0; m_out = '0; m_lock = '0; m_asw = '0;
    lfsr = 32'h1D2C_3B4A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state on outputs and through reads
    check_outputs("R1");
    for (int w = 0; w < 16; w++) begin
      bus_read(AW'(w * 4), r);
      check(w == 4 ? "R4" : "R1", r, model_read(w));
    end

    // R2/R3/R4/R8/R10/R11: write every word, then read all back
    for (int pass = 0; pass < 3; pass++) begin
      for (int w = 0; w < 16; w++) begin
        lfsr = next_rand(lfsr);
        bus_write(AW'(w * 4), lfsr);
        model_write(w, lfsr);
        check_outputs("R11");
      end
      pin_in = lfsr[31:16];
      for (int w = 0; w < 16; w++) begin
        bus_read(AW'(w * 4), r);
        check(tag_of(w), r, model_read(w));
      end
    end

    // R2: read data holds while idle
    bus_read(AW'(8 * 4), r);
    repeat (4) @(negedge clk);
    check("R2", rd_data, m_alo);

    // R10: misaligned accesses
    for (int a = 0; a < 64; a++) begin
      if (a[1:0] != 2'b00) begin
        bus_write(AW'(a), 32'hFFFF_FFFF);
        check_outputs("R10");
        bus_read(AW'(a), r);
        check("R10", r, 32'h0);
      end
    end

    // R10: valid low with write data present
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b1; bus_addr = AW'(5 * 4); bus_wdata = ~{16'h0, m_out};
    @(negedge clk);
    bus_we = 1'b0;
    check_outputs("R10");

    // R5: random set/clear words
    for (int i = 0; i < 64; i++) begin
      lfsr = next_rand(lfsr);
      bus_write(AW'(6 * 4), lfsr);
      model_write(6, lfsr);
      check("R5", {16'h0, out_level}, {16'h0, m_out});
    end

    // R6: set beats clear
    bus_write(AW'(5 * 4), 32'h0000_0000);
    bus_write(AW'(6 * 4), 32'hFFFF_FFFF);
    check("R6", {16'h0, out_level}, 32'h0000_FFFF);
    bus_write(AW'(6 * 4), 32'h00F0_0F0F);
    check("R6", {16'h0, out_level}, 32'h0000_FF0F);
    bus_write(AW'(6 * 4), 32'hFFFF_0000);
    check("R5", {16'h0, out_level}, 32'h0000_0000);
    m_out = 16'h0000;

    // R7: clear-only word, upper half ignored
    bus_write(AW'(5 * 4), 32'h0000_FFFF);
    m_out = 16'hFFFF;
    bus_write(AW'(10 * 4), 32'hFFFF_0000);
    check("R7", {16'h0, out_level}, 32'h0000_FFFF);
    for (int i = 0; i < 32; i++) begin
      lfsr = next_rand(lfsr);
      if (i % 4 == 0) begin
        bus_write(AW'(5 * 4), {16'h0, lfsr[31:16]});
        model_write(5, {16'h0, lfsr[31:16]});
      end
      bus_write(AW'(10 * 4), lfsr);
      model_write(10, lfsr);
      check("R7", {16'h0, out_level}, {16'h0, m_out});
    end

    // R9: every mode code on every pin, then mixed codes
    for (int c = 0; c < 4; c++) begin
      logic [31:0] d;
      d = '0;
      for (int p = 0; p < 16; p++) d[2*p +: 2] = 2'(c);
      bus_write(AW'(0), d);
      m_dir = d;
      check("R9", {16'h0, drive_en}, (c == 1) ? 32'h0000_FFFF : 32'h0);
    end
    for (int s = 0; s < 4; s++) begin
      logic [31:0] d;
      logic [15:0] e;
      d = '0; e = '0;
      for (int p = 0; p < 16; p++) begin
        d[2*p +: 2] = 2'((p + s) % 4);
        e[p] = (((p + s) % 4) == 1);
      end
      bus_write(AW'(0), d);
      m_dir = d;
      check("R9", {16'h0, drive_en}, {16'h0, e});
    end

    // R4: input word reflects pin_in, writes to it ignored
    for (int i = 0; i < 8; i++) begin
      lfsr = next_rand(lfsr);
      pin_in = lfsr[15:0];
      bus_read(AW'(4 * 4), r);
      check("R4", r, {16'h0, lfsr[15:0]});
      bus_write(AW'(4 * 4), ~lfsr);
      check_outputs("R4");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule